// File: doc/BRIEF.md
# Multiword DMA Strobe Timing Generator

This block drives the read and write data strobes of a disk-style DMA port. Each word is one strobe cycle. The cycle has an active phase, when the strobe is high, followed by a recovery phase, when the strobe is low. Both phases are counted in clock ticks.

The block has four fixed timing types, from slowest to fastest A, B, C and D. Each type has its own active and recovery times in nanoseconds. Software loads a transfer-mode code together with a cycle-time value. From these the block works out a requested cycle time, then keeps the fastest type whose full cycle is not shorter than that request.

A transfer request then names a word count and a direction. The block emits one strobe cycle per word, back to back. It pulses a done flag at the end of each word and holds busy for the whole burst. The parameter `CLK_NS` gives the clock period in nanoseconds, and every phase length is derived from it. Reset deassertion is expected to be synchronous to `clk`.

Top module: `mw_strobe_gen`

## Requirements
- R1: While reset is low and directly after it, `rd_strobe`, `wr_strobe`, `word_done` and `busy` are 0, and `timing_type` is 0.
- R2: Timing types are encoded A=0, B=1, C=2 and D=3. Their full cycles are 562, 437, 250 and 187 ns. The type selected is the fastest one whose cycle is at least the requested time. A request above 562 ns selects A.
- R3: `cfg_mode` codes 0, 1 and 2 (single-word modes 0 to 2) and code 3 (multiword mode 0) request 480 ns. Codes 4 and 5 (multiword modes 1 and 2) request 250 ns. Code 6 requests `cfg_cycle_ns` directly. Code 7 is ignored and leaves `timing_type` unchanged.
- R4: For codes 4 and 5, a `cfg_cycle_ns` above 250 raises the request to that value. For codes 0 to 3, `cfg_cycle_ns` has no effect.
- R5: Active and recovery lengths are the nanosecond figure of the chosen type divided by `CLK_NS`, rounded up, with a minimum of 1 tick. The figures are A 250/312, B 187/250, C 125/125 and D 62/125.
- R6: The clock edge that samples `xfer_req` starts the first active phase. For each word the strobe is high for the active length and then low for the recovery length. The next word follows with no gap.
- R7: `word_done` is a one-cycle pulse in the last recovery cycle of every word.
- R8: `busy` rises together with the first active phase and stays high for exactly words × (active + recovery) cycles. No strobe is high while `busy` is low.
- R9: When `xfer_wr` is 1 at the request, the burst uses `wr_strobe`; when it is 0, the burst uses `rd_strobe`. The two strobes are never high together.
- R10: `xfer_req` is ignored while `busy` is high. It is also ignored when `xfer_words` is 0.
- R11: `cfg_load` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load a new timing configuration |
| cfg_mode | input | 3 | Transfer-mode code (see R3) |
| cfg_cycle_ns | input | NS_W | Drive minimum cycle time, or explicit cycle time for code 6 |
| xfer_req | input | 1 | Start a burst |
| xfer_wr | input | 1 | Burst direction, 1 = write |
| xfer_words | input | WORDS_W | Number of words in the burst |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| word_done | output | 1 | End-of-word pulse |
| busy | output | 1 | Burst in progress |
| timing_type | output | 2 | Selected timing type |

## Verification
The bench builds the block with `CLK_NS` = 20, `NS_W` = 16 and `WORDS_W` = 8. With these values the phases last between 4 and 16 ticks. Most of the nanosecond figures are not whole multiples of 20, so the round-up rule of R5 is exercised on every type. The explicit-cycle code reaches type D and the cycle boundaries at 187/188, 437/438 and 562/563 ns.

// File: rtl/mwdma_pkg.sv
package mwdma_pkg;

  typedef enum logic [1:0] {
    TT_A = 2'd0,
    TT_B = 2'd1,
    TT_C = 2'd2,
    TT_D = 2'd3
  } tim_type_e;

  typedef enum logic [2:0] {
    XM_SW0  = 3'd0,
    XM_SW1  = 3'd1,
    XM_SW2  = 3'd2,
    XM_MW0  = 3'd3,
    XM_MW1  = 3'd4,
    XM_MW2  = 3'd5,
    XM_EXPL = 3'd6,
    XM_RSVD = 3'd7
  } xfer_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ACT  = 2'd1,
    PH_REC  = 2'd2
  } phase_e;

  localparam int unsigned NUM_TYPES    = 4;
  localparam int unsigned SLOW_REQ_NS  = 480;
  localparam int unsigned FAST_REQ_NS  = 250;
  localparam int unsigned MAX_PHASE_NS = 312;

  // active time per type, index = type encoding
  function automatic int unsigned act_ns(int unsigned t);
    case (t)
      0:       return 250;
      1:       return 187;
      2:       return 125;
      default: return 62;
    endcase
  endfunction

  // recovery time per type
  function automatic int unsigned rec_ns(int unsigned t);
    case (t)
      0:       return 312;
      1:       return 250;
      default: return 125;
    endcase
  endfunction

  // ceiling division, floor of one tick
  function automatic int unsigned ns_to_ticks(int unsigned ns, int unsigned clk_ns);
    int unsigned t;
    t = (ns + clk_ns - 1) / clk_ns;
    if (t < 1) t = 1;
    return t;
  endfunction

endpackage

// File: rtl/mwdma_cycle_pick.sv
module mwdma_cycle_pick
  import mwdma_pkg::*;
#(
  parameter int unsigned NS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic            busy,
  input  logic [2:0]      cfg_mode,
  input  logic [NS_W-1:0] cfg_cycle_ns,
  output tim_type_e       type_q
);

  logic [NS_W-1:0]      req_ns;
  logic                 mode_ok;
  logic [NUM_TYPES-1:0] fits;
  tim_type_e            pick;
  logic                 load_en;

  // requested cycle time from the mode code
  always_comb begin
    req_ns  = NS_W'(SLOW_REQ_NS);
    mode_ok = 1'b1;
    case (xfer_mode_e'(cfg_mode))
      XM_SW0, XM_SW1, XM_SW2, XM_MW0: req_ns = NS_W'(SLOW_REQ_NS);
      XM_MW1, XM_MW2: begin
        if (cfg_cycle_ns > NS_W'(FAST_REQ_NS)) req_ns = cfg_cycle_ns;
        else                                   req_ns = NS_W'(FAST_REQ_NS);
      end
      XM_EXPL: req_ns = cfg_cycle_ns;
      default: mode_ok = 1'b0;
    endcase
  end

  // one comparator per type against its fixed total cycle
  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_fit
    localparam int unsigned CYC_NS = act_ns(t) + rec_ns(t);
    assign fits[t] = (req_ns <= NS_W'(CYC_NS));
  end

  // cycles shrink with the index, so the highest fitting index is the fastest
  always_comb begin
    pick = TT_A;
    for (int t = 0; t < NUM_TYPES; t++) begin
      if (fits[t]) pick = tim_type_e'(t);
    end
  end

  assign load_en = cfg_load & ~busy & mode_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       type_q <= TT_A;
    else if (load_en) type_q <= pick;
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(type_q));

  // R3
  bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && cfg_mode == 3'd7) |=> $stable(type_q));

endmodule

// File: rtl/mwdma_phase_lut.sv
module mwdma_phase_lut
  import mwdma_pkg::*;
#(
  parameter int unsigned CLK_NS = 20,
  parameter int unsigned TICK_W = 5
) (
  input  tim_type_e         sel,
  output logic [TICK_W-1:0] act_len,
  output logic [TICK_W-1:0] rec_len
);

  logic [TICK_W-1:0] act_tab [NUM_TYPES];
  logic [TICK_W-1:0] rec_tab [NUM_TYPES];
  logic [1:0]        idx;

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_tab
    localparam int unsigned ACT_T = ns_to_ticks(act_ns(t), CLK_NS);
    localparam int unsigned REC_T = ns_to_ticks(rec_ns(t), CLK_NS);
    assign act_tab[t] = TICK_W'(ACT_T);
    assign rec_tab[t] = TICK_W'(REC_T);
  end

  assign idx     = sel;
  assign act_len = act_tab[idx];
  assign rec_len = rec_tab[idx];

endmodule

// File: rtl/mwdma_burst_fsm.sv
module mwdma_burst_fsm
  import mwdma_pkg::*;
#(
  parameter int unsigned TICK_W  = 5,
  parameter int unsigned WORDS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer_req,
  input  logic               xfer_wr,
  input  logic [WORDS_W-1:0] xfer_words,
  input  logic [TICK_W-1:0]  act_len,
  input  logic [TICK_W-1:0]  rec_len,
  output logic               rd_strobe,
  output logic               wr_strobe,
  output logic               word_done,
  output logic               busy
);

  phase_e             ph_q, ph_d;
  logic [TICK_W-1:0]  cnt_q, cnt_d;
  logic [WORDS_W-1:0] left_q, left_d;
  logic [TICK_W-1:0]  act_q, rec_q;
  logic               wr_q;
  logic               start;
  logic               phase_end;
  logic               strobe_any;

  assign start     = (ph_q == PH_IDLE) && xfer_req && (xfer_words != '0);
  assign phase_end = (cnt_q == '0);

  // next-state logic
  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    left_d    = left_q;
    word_done = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d   = PH_ACT;
          cnt_d  = act_len - TICK_W'(1);
          left_d = xfer_words;
        end
      end
      PH_ACT: begin
        if (phase_end) begin
          ph_d  = PH_REC;
          cnt_d = rec_q - TICK_W'(1);
        end else begin
          cnt_d = cnt_q - TICK_W'(1);
        end
      end
      PH_REC: begin
        if (phase_end) begin
          word_done = 1'b1;
          if (left_q == WORDS_W'(1)) begin
            ph_d = PH_IDLE;
          end else begin
            ph_d   = PH_ACT;
            cnt_d  = act_q - TICK_W'(1);
            left_d = left_q - WORDS_W'(1);
          end
        end else begin
          cnt_d = cnt_q - TICK_W'(1);
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
    end
  end

  // burst-wide settings captured once at start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      rec_q <= '0;
      wr_q  <= 1'b0;
    end else if (start) begin
      act_q <= act_len;
      rec_q <= rec_len;
      wr_q  <= xfer_wr;
    end
  end

  assign strobe_any = (ph_q == PH_ACT);
  assign rd_strobe  = strobe_any & ~wr_q;
  assign wr_strobe  = strobe_any &  wr_q;
  assign busy       = (ph_q != PH_IDLE);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // R7
  done_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (busy && !rd_strobe && !wr_strobe));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (rd_strobe || wr_strobe));

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_done) |=> busy);

  // R9
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !word_done) |=> !wr_strobe);

endmodule

// File: rtl/mw_strobe_gen.sv
module mw_strobe_gen
  import mwdma_pkg::*;
#(
  parameter int unsigned CLK_NS  = 20,
  parameter int unsigned NS_W    = 16,
  parameter int unsigned WORDS_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_load,
  input  logic [2:0]         cfg_mode,
  input  logic [NS_W-1:0]    cfg_cycle_ns,
  input  logic               xfer_req,
  input  logic               xfer_wr,
  input  logic [WORDS_W-1:0] xfer_words,
  output logic               rd_strobe,
  output logic               wr_strobe,
  output logic               word_done,
  output logic               busy,
  output logic [1:0]         timing_type
);

  localparam int unsigned MAX_TICKS = ns_to_ticks(MAX_PHASE_NS, CLK_NS);
  localparam int unsigned TICK_W    = $clog2(MAX_TICKS + 1);

  tim_type_e         type_q;
  logic [TICK_W-1:0] act_len;
  logic [TICK_W-1:0] rec_len;

  mwdma_cycle_pick #(.NS_W(NS_W)) u_pick (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_load     (cfg_load),
    .busy         (busy),
    .cfg_mode     (cfg_mode),
    .cfg_cycle_ns (cfg_cycle_ns),
    .type_q       (type_q)
  );

  mwdma_phase_lut #(.CLK_NS(CLK_NS), .TICK_W(TICK_W)) u_lut (
    .sel     (type_q),
    .act_len (act_len),
    .rec_len (rec_len)
  );

  mwdma_burst_fsm #(.TICK_W(TICK_W), .WORDS_W(WORDS_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_req   (xfer_req),
    .xfer_wr    (xfer_wr),
    .xfer_words (xfer_words),
    .act_len    (act_len),
    .rec_len    (rec_len),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .word_done  (word_done),
    .busy       (busy)
  );

  assign timing_type = type_q;

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_strobe && !wr_strobe && !word_done));

endmodule

// File: tb/sim_mw_strobe_gen.sv
module sim_mw_strobe_gen;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CLK_NS = 20;

  typedef struct packed {
    logic        wr;
    logic [15:0] act;
    logic [15:0] rec;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [2:0]  cfg_mode;
  logic [15:0] cfg_cycle_ns;
  logic        xfer_req;
  logic        xfer_wr;
  logic [7:0]  xfer_words;
  logic        rd_strobe, wr_strobe, word_done, busy;
  logic [1:0]  timing_type;

  int    checks = 0;
  int    errors = 0;
  int    cur_type = 0;
  bit    finished = 1'b0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  mw_strobe_gen #(.CLK_NS(CLK_NS), .NS_W(16), .WORDS_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_cycle_ns(cfg_cycle_ns), .xfer_req(xfer_req), .xfer_wr(xfer_wr),
    .xfer_words(xfer_words), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .word_done(word_done), .busy(busy), .timing_type(timing_type)
  );

  task automatic chk(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // model of R2 and R5 from the stated figures
  function automatic int m_act_ns(int t);
    case (t) 0: return 250; 1: return 187; 2: return 125; default: return 62; endcase
  endfunction
  function automatic int m_rec_ns(int t);
    case (t) 0: return 312; 1: return 250; default: return 125; endcase
  endfunction
  function automatic int m_ticks(int ns);
    int t;
    t = (ns + CLK_NS - 1) / CLK_NS;
    return (t < 1) ? 1 : t;
  endfunction
  function automatic int m_type(int req);
    if (req <= 187) return 3;
    if (req <= 250) return 2;
    if (req <= 437) return 1;
    return 0;
  endfunction

  // scoreboard monitor
  int    mon_act = 0;
  int    mon_rec = 0;
  bit    mon_wr  = 1'b0;
  item_t it;
  always @(negedge clk) begin
    if (!rst_n) begin
      mon_act = 0;
      mon_rec = 0;
    end else begin
      if (rd_strobe && wr_strobe) chk(1'b0, "R9 both strobes high", 1, 0);
      if (!busy && (rd_strobe || wr_strobe)) chk(1'b0, "R8 strobe outside busy", 1, 0);
      if (rd_strobe || wr_strobe) begin
        mon_act++;
        mon_wr = wr_strobe;
      end else if (busy) begin
        mon_rec++;
      end
      if (word_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7 R10 unexpected word_done", 1, 0);
        end else begin
          it = exp_q.pop_front();
          chk(mon_act == int'(it.act), "R5 R6 active ticks", mon_act, int'(it.act));
          chk(mon_rec == int'(it.rec), "R5 R6 recovery ticks", mon_rec, int'(it.rec));
          chk(mon_wr == it.wr, "R9 direction", int'(mon_wr), int'(it.wr));
        end
        mon_act = 0;
        mon_rec = 0;
      end
    end
  end

  task automatic configure(int mode, int cyc, string tag);
    int req;
    bit ok;
    ok = 1'b1;
    req = 480;
    if (mode <= 3)      req = 480;
    else if (mode <= 5) req = (cyc > 250) ? cyc : 250;
    else if (mode == 6) req = cyc;
    else                ok = 1'b0;
    if (ok) cur_type = m_type(req);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = 3'(mode); cfg_cycle_ns = 16'(cyc);
    @(negedge clk);
    cfg_load = 1'b0;
    chk(int'(timing_type) == cur_type, tag, int'(timing_type), cur_type);
  endtask

  task automatic burst(int n, bit wr, bit poke, string tag);
    int a, r, cnt;
    item_t x;
    a = m_ticks(m_act_ns(cur_type));
    r = m_ticks(m_rec_ns(cur_type));
    for (int i = 0; i < n; i++) begin
      x.wr = wr; x.act = 16'(a); x.rec = 16'(r);
      exp_q.push_back(x);
    end
    @(negedge clk);
    xfer_req = 1'b1; xfer_words = 8'(n); xfer_wr = wr;
    @(negedge clk);
    xfer_req = 1'b0; xfer_words = 8'd0;
    chk(busy == 1'b1, {tag, " R8 busy at first active"}, int'(busy), 1);
    chk((wr ? wr_strobe : rd_strobe) == 1'b1, {tag, " R6 strobe right after request"}, 0, 1);
    cnt = 1;
    while (busy) begin
      if (poke && cnt == 3) begin
        xfer_req = 1'b1; xfer_words = 8'd5; xfer_wr = ~wr;
        cfg_load = 1'b1; cfg_mode = 3'd6; cfg_cycle_ns = 16'd100;
      end
      @(negedge clk);
      xfer_req = 1'b0; xfer_words = 8'd0; cfg_load = 1'b0;
      if (busy) cnt++;
    end
    chk(cnt == n * (a + r), {tag, " R8 busy length"}, cnt, n * (a + r));
    chk(exp_q.size() == 0, {tag, " R7 all words done"}, exp_q.size(), 0);
    if (poke) begin
      chk(int'(timing_type) == cur_type, {tag, " R11 cfg ignored while busy"},
          int'(timing_type), cur_type);
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, {tag, " R10 request while busy ignored"}, int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_load = 1'b0; cfg_mode = 3'd0; cfg_cycle_ns = 16'd0;
    xfer_req = 1'b0; xfer_wr = 1'b0; xfer_words = 8'd0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && rd_strobe == 1'b0 && wr_strobe == 1'b0,
        "R1 outputs low in reset", int'(busy), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(timing_type == 2'd0, "R1 type after reset", int'(timing_type), 0);
    chk(word_done == 1'b0 && busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    configure(3, 0, "R3 MW0 to A");
    burst(2, 1'b0, 1'b0, "R6 read on A");
    configure(4, 0, "R3 MW1 to C");
    burst(3, 1'b1, 1'b0, "R9 write on C");
    configure(5, 300, "R4 MW2 raised to B");
    burst(1, 1'b0, 1'b0, "R6 single word on B");
    configure(4, 200, "R4 lower minimum unused");
    configure(0, 1000, "R4 SW0 ignores minimum");
    configure(6, 187, "R2 boundary 187 to D");
    burst(2, 1'b1, 1'b0, "R5 write on D");
    configure(6, 188, "R2 188 to C");
    configure(6, 437, "R2 437 to B");
    configure(6, 438, "R2 438 to A");
    configure(6, 1, "R2 tiny to D");
    configure(6, 563, "R2 none fits to A");
    configure(4, 0, "R3 MW1 to C again");
    configure(7, 100, "R3 reserved code ignored");
    configure(2, 0, "R3 SW2 to A");
    burst(3, 1'b0, 1'b1, "R10 R11 poke");

    @(negedge clk);
    xfer_req = 1'b1; xfer_words = 8'd0;
    @(negedge clk);
    xfer_req = 1'b0;
    chk(busy == 1'b0, "R10 zero words ignored", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && exp_q.size() == 0, "R10 still idle", int'(busy), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule